// File: doc/BRIEF.md
# Interrupt Frame Sequencer

This block carries out the memory work a 16-bit segmented processor needs when it enters or leaves an interrupt handler. An entry is requested either directly with an interrupt type number, for example from a request arbiter, or by handing over one of three software-interrupt opcode bytes from the instruction decoder. The sequencer saves the flags word, the return code segment and the return offset on the stack. It then reads the handler offset and segment from a 256-entry vector table at the bottom of memory, loads them as the new IP and CS, and clears the trap and interrupt-enable flags. A return command undoes the frame. It reloads IP, CS and the flags from the stack and releases the three words.

The sequencer holds the stack pointer, flags, code segment and instruction pointer itself. The execution unit can write these registers through a small write port while the block is idle. The stack segment is an input. Memory is reached through a word-wide request/acknowledge port, and the block waits in each access until it is acknowledged. Each operation ends with a one-cycle done pulse.

Top module: `int_frame_seq`

## Requirements
- R1: An entry makes three word writes, in this order: flags, CS, then IP. They go to stack addresses SS×16+SP−2, −4 and −6. SP is decremented by 2 before each write and ends 6 lower.
- R2: After the pushes, the word at byte address type×4 is loaded into IP and the word at type×4+2 into CS. These are 20-bit addresses, so the table spans 1 KiB from address 0.
- R3: When an entry completes, flag bit 9 (interrupt enable) and flag bit 8 (trap) read 0, and every other flag bit is unchanged.
- R4: A return reads IP from SS×16+SP, CS from +2 and flags from +4, in that order. SP is incremented by 2 after each read. IP, CS, flags and SP then equal their values from before the matching entry.
- R5: A software opcode byte CDh with immediate byte N starts an entry with type N.
- R6: A software opcode byte CCh starts an entry with type 3.
- R7: A software opcode byte CEh starts an entry with type 4 when flag bit 11 (overflow) is 1. When that bit is 0, the block pulses done with no memory request and changes no register.
- R8: A software opcode byte other than CDh, CCh or CEh is ignored: busy stays low, no memory request is made and no register changes.
- R9: busy is high from the cycle after a command is accepted through the done cycle. done is high for exactly one cycle. Commands presented while busy is high are ignored.
- R10: While a memory request is waiting for its acknowledge, the request, the write enable, the address and the write data hold steady.
- R11: After reset, SP=FFFEh, flags=0002h, CS=FFFFh and IP=0000h. The write port selects SP, flags, CS or IP with codes 0, 1, 2 and 3, and it takes effect only while the block is idle.
- R12: When several commands arrive in the same cycle, a direct type request wins over a software opcode, and a recognised software opcode wins over a return.
- R13: Stack addresses wrap modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Direct entry request |
| start_type_i | input | 8 | Type number for a direct entry |
| swi_valid_i | input | 1 | A software-interrupt opcode byte is presented |
| swi_op_i | input | 8 | Opcode byte |
| swi_imm_i | input | 8 | Immediate byte that follows the opcode |
| ret_i | input | 1 | Return-from-handler request |
| ss_i | input | 16 | Stack segment |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 SP, 1 flags, 2 CS, 3 IP |
| wr_data_i | input | 16 | Register write value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 20 | Byte address of the word |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access completed |
| mem_rdata_i | input | 16 | Read data, valid with the acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 16 | Flags register |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |

## Verification
The bench builds the block with its default parameters: 16-bit words, an 8-bit type number, a segment shift of 4, and the trap, enable and overflow flags at bits 8, 9 and 11. These defaults make the whole 256-entry vector table reachable, including types 00h and FFh. They also let a stack segment of FFFFh push the frame across the 20-bit wrap point. Acknowledge latencies from zero to three extra cycles exercise the stall behaviour. The taken and not-taken forms of the overflow trap are both driven.

// File: rtl/ifs_pkg.sv
// Shared types for the interrupt frame sequencer.
// Assumes opcode bytes are 8 bits wide regardless of the type-number width.
package ifs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_FL,
        ST_PUSH_CS,
        ST_PUSH_IP,
        ST_RD_IP,
        ST_RD_CS,
        ST_POP_IP,
        ST_POP_CS,
        ST_POP_FL,
        ST_FINISH
    } ifs_state_e;

    typedef enum logic [1:0] {
        SEL_SP    = 2'd0,
        SEL_FLAGS = 2'd1,
        SEL_CS    = 2'd2,
        SEL_IP    = 2'd3
    } ifs_wsel_e;

    localparam logic [7:0] OPC_TRAP_N   = 8'hCD;
    localparam logic [7:0] OPC_TRAP_BRK = 8'hCC;
    localparam logic [7:0] OPC_TRAP_OVF = 8'hCE;
    localparam int         TYPE_BRK     = 3;
    localparam int         TYPE_OVF     = 4;

endpackage

// File: rtl/ifs_decode.sv
// Command decoder: picks one command per cycle (direct > software opcode > return)
// and derives the interrupt type. Assumes the caller only uses the outputs when idle.
module ifs_decode
    import ifs_pkg::*;
#(
    parameter int TYPE_W = 8
) (
    input  logic              start_i,
    input  logic [TYPE_W-1:0] start_type_i,
    input  logic              swi_valid_i,
    input  logic [7:0]        swi_op_i,
    input  logic [7:0]        swi_imm_i,
    input  logic              ret_i,
    input  logic              ovf_flag_i,
    output logic              go_entry_o,
    output logic              go_skip_o,
    output logic              go_ret_o,
    output logic [TYPE_W-1:0] type_o
);

    logic swi_entry;
    logic swi_skip;
    logic [TYPE_W-1:0] swi_type;

    // Classify the software opcode byte.
    always_comb begin
        swi_entry = 1'b0;
        swi_skip  = 1'b0;
        swi_type  = TYPE_W'(swi_imm_i);
        if (swi_valid_i) begin
            case (swi_op_i)
                OPC_TRAP_N: begin
                    swi_entry = 1'b1;
                end
                OPC_TRAP_BRK: begin
                    swi_entry = 1'b1;
                    swi_type  = TYPE_W'(TYPE_BRK);
                end
                OPC_TRAP_OVF: begin
                    swi_type  = TYPE_W'(TYPE_OVF);
                    swi_entry = ovf_flag_i;
                    swi_skip  = !ovf_flag_i;
                end
                default: ;
            endcase
        end
    end

    // Apply the command priority.
    always_comb begin
        go_entry_o = 1'b0;
        go_skip_o  = 1'b0;
        go_ret_o   = 1'b0;
        type_o     = start_type_i;
        if (start_i) begin
            go_entry_o = 1'b1;
        end else if (swi_entry || swi_skip) begin
            go_entry_o = swi_entry;
            go_skip_o  = swi_skip;
            type_o     = swi_type;
        end else if (ret_i) begin
            go_ret_o = 1'b1;
        end
    end

endmodule

// File: rtl/ifs_agen.sv
// Memory request generator: forms the address, direction and data of the access
// that belongs to the current state. Stack addresses are SS<<SEG_SHIFT + SP, which
// wraps naturally at the address width.
module ifs_agen
    import ifs_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int TYPE_W    = 8,
    parameter int SEG_SHIFT = 4
) (
    input  ifs_state_e                  st_i,
    input  logic [WORD_W-1:0]           ss_i,
    input  logic [WORD_W-1:0]           sp_i,
    input  logic [WORD_W-1:0]           flags_i,
    input  logic [WORD_W-1:0]           cs_i,
    input  logic [WORD_W-1:0]           ip_i,
    input  logic [TYPE_W-1:0]           type_i,
    output logic                        req_o,
    output logic                        we_o,
    output logic [WORD_W+SEG_SHIFT-1:0] addr_o,
    output logic [WORD_W-1:0]           wdata_o
);

    localparam int ADDR_W = WORD_W + SEG_SHIFT;
    localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

    logic [WORD_W-1:0] sp_push;
    logic [ADDR_W-1:0] seg_base;
    logic [ADDR_W-1:0] stack_push;
    logic [ADDR_W-1:0] stack_pop;
    logic [ADDR_W-1:0] vec_lo;
    logic [ADDR_W-1:0] vec_hi;

    assign sp_push    = sp_i - STEP;
    assign seg_base   = {ss_i, {SEG_SHIFT{1'b0}}};
    assign stack_push = seg_base + ADDR_W'(sp_push);
    assign stack_pop  = seg_base + ADDR_W'(sp_i);
    assign vec_lo     = ADDR_W'({type_i, 2'b00});
    assign vec_hi     = vec_lo + ADDR_W'(2);

    // Select the access for the current state.
    always_comb begin
        req_o   = 1'b1;
        we_o    = 1'b0;
        addr_o  = stack_pop;
        wdata_o = flags_i;
        case (st_i)
            ST_PUSH_FL: begin
                we_o    = 1'b1;
                addr_o  = stack_push;
                wdata_o = flags_i;
            end
            ST_PUSH_CS: begin
                we_o    = 1'b1;
                addr_o  = stack_push;
                wdata_o = cs_i;
            end
            ST_PUSH_IP: begin
                we_o    = 1'b1;
                addr_o  = stack_push;
                wdata_o = ip_i;
            end
            ST_RD_IP:  addr_o = vec_lo;
            ST_RD_CS:  addr_o = vec_hi;
            ST_POP_IP, ST_POP_CS, ST_POP_FL: addr_o = stack_pop;
            default:   req_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ifs_regs.sv
// Architectural register set owned by the sequencer: SP, flags, CS, IP.
// Assumes the controller raises at most one of the update strobes for a register
// per cycle; the write port is already qualified with idle by the caller.
module ifs_regs
    import ifs_pkg::*;
#(
    parameter int              WORD_W    = 16,
    parameter int              TF_BIT    = 8,
    parameter int              IF_BIT    = 9,
    parameter logic [WORD_W-1:0] RST_SP    = 16'hFFFE,
    parameter logic [WORD_W-1:0] RST_FLAGS = 16'h0002,
    parameter logic [WORD_W-1:0] RST_CS    = 16'hFFFF,
    parameter logic [WORD_W-1:0] RST_IP    = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic              sp_dec_i,
    input  logic              sp_inc_i,
    input  logic              ld_ip_i,
    input  logic              ld_cs_i,
    input  logic              ld_fl_i,
    input  logic              clr_mask_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic [WORD_W-1:0] sp_o,
    output logic [WORD_W-1:0] flags_o,
    output logic [WORD_W-1:0] cs_o,
    output logic [WORD_W-1:0] ip_o
);

    localparam logic [WORD_W-1:0] STEP      = WORD_W'(2);
    localparam logic [WORD_W-1:0] ENTRY_CLR = (WORD_W'(1) << TF_BIT) | (WORD_W'(1) << IF_BIT);

    logic wr_sp, wr_fl, wr_cs, wr_ip;

    assign wr_sp = wr_en_i && (ifs_wsel_e'(wr_sel_i) == SEL_SP);
    assign wr_fl = wr_en_i && (ifs_wsel_e'(wr_sel_i) == SEL_FLAGS);
    assign wr_cs = wr_en_i && (ifs_wsel_e'(wr_sel_i) == SEL_CS);
    assign wr_ip = wr_en_i && (ifs_wsel_e'(wr_sel_i) == SEL_IP);

    // Stack pointer: external write, pre-decrement on push, post-increment on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)        sp_o <= RST_SP;
        else if (wr_sp)    sp_o <= wr_data_i;
        else if (sp_dec_i) sp_o <= sp_o - STEP;
        else if (sp_inc_i) sp_o <= sp_o + STEP;
    end

    // Flags: external write, restore on pop, clear enable and trap on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          flags_o <= RST_FLAGS;
        else if (wr_fl)      flags_o <= wr_data_i;
        else if (ld_fl_i)    flags_o <= rdata_i;
        else if (clr_mask_i) flags_o <= flags_o & ~ENTRY_CLR;
    end

    // Code segment: external write or load from vector table / stack.
    always_ff @(posedge clk) begin
        if (!rst_n)       cs_o <= RST_CS;
        else if (wr_cs)   cs_o <= wr_data_i;
        else if (ld_cs_i) cs_o <= rdata_i;
    end

    // Instruction pointer: external write or load from vector table / stack.
    always_ff @(posedge clk) begin
        if (!rst_n)       ip_o <= RST_IP;
        else if (wr_ip)   ip_o <= wr_data_i;
        else if (ld_ip_i) ip_o <= rdata_i;
    end

endmodule

// File: rtl/int_frame_seq.sv
// Interrupt frame sequencer top: state machine that walks the push, vector read
// and pop sequences, one memory word per state, advancing only on acknowledge.
// Assumes the memory holds the acknowledge for one cycle per request.
module int_frame_seq
    import ifs_pkg::*;
#(
    parameter int                WORD_W    = 16,
    parameter int                TYPE_W    = 8,
    parameter int                SEG_SHIFT = 4,
    parameter int                TF_BIT    = 8,
    parameter int                IF_BIT    = 9,
    parameter int                OF_BIT    = 11,
    parameter logic [WORD_W-1:0] RST_SP    = 16'hFFFE,
    parameter logic [WORD_W-1:0] RST_FLAGS = 16'h0002,
    parameter logic [WORD_W-1:0] RST_CS    = 16'hFFFF,
    parameter logic [WORD_W-1:0] RST_IP    = 16'h0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [TYPE_W-1:0]           start_type_i,
    input  logic                        swi_valid_i,
    input  logic [7:0]                  swi_op_i,
    input  logic [7:0]                  swi_imm_i,
    input  logic                        ret_i,
    input  logic [WORD_W-1:0]           ss_i,
    input  logic                        wr_en_i,
    input  logic [1:0]                  wr_sel_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    output logic                        mem_req_o,
    output logic                        mem_we_o,
    output logic [WORD_W+SEG_SHIFT-1:0] mem_addr_o,
    output logic [WORD_W-1:0]           mem_wdata_o,
    input  logic                        mem_ack_i,
    input  logic [WORD_W-1:0]           mem_rdata_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic [WORD_W-1:0]           sp_o,
    output logic [WORD_W-1:0]           flags_o,
    output logic [WORD_W-1:0]           cs_o,
    output logic [WORD_W-1:0]           ip_o
);

    ifs_state_e        st_q, st_d;
    logic [TYPE_W-1:0] type_q;
    logic [TYPE_W-1:0] dec_type;
    logic              go_entry, go_skip, go_ret;
    logic              idle, ack_ok;
    logic              in_push, in_pop;

    assign idle    = (st_q == ST_IDLE);
    assign ack_ok  = mem_req_o && mem_ack_i;
    assign in_push = (st_q == ST_PUSH_FL) || (st_q == ST_PUSH_CS) || (st_q == ST_PUSH_IP);
    assign in_pop  = (st_q == ST_POP_IP) || (st_q == ST_POP_CS) || (st_q == ST_POP_FL);
    assign busy_o  = !idle;
    assign done_o  = (st_q == ST_FINISH);

    ifs_decode #(.TYPE_W(TYPE_W)) dec_i (
        .start_i      (start_i),
        .start_type_i (start_type_i),
        .swi_valid_i  (swi_valid_i),
        .swi_op_i     (swi_op_i),
        .swi_imm_i    (swi_imm_i),
        .ret_i        (ret_i),
        .ovf_flag_i   (flags_o[OF_BIT]),
        .go_entry_o   (go_entry),
        .go_skip_o    (go_skip),
        .go_ret_o     (go_ret),
        .type_o       (dec_type)
    );

    // Next-state logic: accept in idle, advance each memory state on acknowledge.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (go_entry)     st_d = ST_PUSH_FL;
                else if (go_skip) st_d = ST_FINISH;
                else if (go_ret)  st_d = ST_POP_IP;
            end
            ST_PUSH_FL: if (ack_ok) st_d = ST_PUSH_CS;
            ST_PUSH_CS: if (ack_ok) st_d = ST_PUSH_IP;
            ST_PUSH_IP: if (ack_ok) st_d = ST_RD_IP;
            ST_RD_IP:   if (ack_ok) st_d = ST_RD_CS;
            ST_RD_CS:   if (ack_ok) st_d = ST_FINISH;
            ST_POP_IP:  if (ack_ok) st_d = ST_POP_CS;
            ST_POP_CS:  if (ack_ok) st_d = ST_POP_FL;
            ST_POP_FL:  if (ack_ok) st_d = ST_FINISH;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Capture the interrupt type when an entry is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)               type_q <= '0;
        else if (idle && go_entry) type_q <= dec_type;
    end

    ifs_agen #(
        .WORD_W    (WORD_W),
        .TYPE_W    (TYPE_W),
        .SEG_SHIFT (SEG_SHIFT)
    ) agen_i (
        .st_i    (st_q),
        .ss_i    (ss_i),
        .sp_i    (sp_o),
        .flags_i (flags_o),
        .cs_i    (cs_o),
        .ip_i    (ip_o),
        .type_i  (type_q),
        .req_o   (mem_req_o),
        .we_o    (mem_we_o),
        .addr_o  (mem_addr_o),
        .wdata_o (mem_wdata_o)
    );

    ifs_regs #(
        .WORD_W    (WORD_W),
        .TF_BIT    (TF_BIT),
        .IF_BIT    (IF_BIT),
        .RST_SP    (RST_SP),
        .RST_FLAGS (RST_FLAGS),
        .RST_CS    (RST_CS),
        .RST_IP    (RST_IP)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i && idle),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .sp_dec_i   (ack_ok && in_push),
        .sp_inc_i   (ack_ok && in_pop),
        .ld_ip_i    (ack_ok && ((st_q == ST_RD_IP) || (st_q == ST_POP_IP))),
        .ld_cs_i    (ack_ok && ((st_q == ST_RD_CS) || (st_q == ST_POP_CS))),
        .ld_fl_i    (ack_ok && (st_q == ST_POP_FL)),
        .clr_mask_i (ack_ok && (st_q == ST_RD_CS)),
        .rdata_i    (mem_rdata_i),
        .sp_o       (sp_o),
        .flags_o    (flags_o),
        .cs_o       (cs_o),
        .ip_o       (ip_o)
    );

endmodule

// File: rtl/ifs_chk.sv
// Property checker for the interrupt frame sequencer, bound to every instance.
module ifs_chk
    import ifs_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int TYPE_W    = 8,
    parameter int SEG_SHIFT = 4,
    parameter int TF_BIT    = 8,
    parameter int IF_BIT    = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input ifs_state_e                  st,
    input logic                        mem_req,
    input logic                        mem_we,
    input logic [WORD_W+SEG_SHIFT-1:0] mem_addr,
    input logic [WORD_W-1:0]           mem_wdata,
    input logic                        mem_ack,
    input logic [WORD_W-1:0]           mem_rdata,
    input logic                        busy,
    input logic                        done,
    input logic [WORD_W-1:0]           sp,
    input logic [WORD_W-1:0]           flags
);

    localparam int ADDR_W = WORD_W + SEG_SHIFT;

    logic push_st, pop_st;
    assign push_st = (st == ST_PUSH_FL) || (st == ST_PUSH_CS) || (st == ST_PUSH_IP);
    assign pop_st  = (st == ST_POP_IP) || (st == ST_POP_CS) || (st == ST_POP_FL);

    AST_PUSH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        push_st |-> mem_req && mem_we);  // R1
    AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
        push_st && mem_ack |=> sp == $past(sp) - WORD_W'(2));  // R1
    AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_RD_IP |-> !mem_we && mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:TYPE_W+2] == '0);  // R2
    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_RD_CS && mem_ack |=> !flags[IF_BIT] && !flags[TF_BIT]);  // R3
    AST_POP_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
        pop_st && mem_ack |=> sp == $past(sp) + WORD_W'(2));  // R4
    AST_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_POP_FL && mem_ack |=> flags == $past(mem_rdata));  // R4
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);  // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));  // R10

endmodule

bind int_frame_seq ifs_chk #(
    .WORD_W    (WORD_W),
    .TYPE_W    (TYPE_W),
    .SEG_SHIFT (SEG_SHIFT),
    .TF_BIT    (TF_BIT),
    .IF_BIT    (IF_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st_q),
    .mem_req   (mem_req_o),
    .mem_we    (mem_we_o),
    .mem_addr  (mem_addr_o),
    .mem_wdata (mem_wdata_o),
    .mem_ack   (mem_ack_i),
    .mem_rdata (mem_rdata_i),
    .busy      (busy_o),
    .done      (done_o),
    .sp        (sp_o),
    .flags     (flags_o)
);

// File: tb/int_frame_seq_tb_top.sv
`timescale 1ns/1ps
module int_frame_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  start_type_i = '0;
    logic        swi_valid_i = 1'b0;
    logic [7:0]  swi_op_i = '0;
    logic [7:0]  swi_imm_i = '0;
    logic        ret_i = 1'b0;
    logic [15:0] ss_i = 16'h0010;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        mem_req_o, mem_we_o;
    logic [19:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic        mem_ack_i;
    logic [15:0] mem_rdata_i;
    logic        busy_o, done_o;
    logic [15:0] sp_o, flags_o, cs_o, ip_o;

    int n_chk = 0;
    int n_fail = 0;
    int lat = 0;

    always #10 clk = ~clk;

    int_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_type_i(start_type_i),
        .swi_valid_i(swi_valid_i), .swi_op_i(swi_op_i), .swi_imm_i(swi_imm_i),
        .ret_i(ret_i), .ss_i(ss_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o),
        .sp_o(sp_o), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o)
    );

    // Memory model: 8 KiB of words, vector table filled during reset.
    logic [15:0] mem [0:4095];
    int          wcnt;
    int          acc_total;
    int          stall_bad;
    logic [19:0] wr_hist [0:2];
    logic [19:0] prev_addr;
    logic        prev_we;

    always @(posedge clk) begin
        prev_addr <= mem_addr_o;
        prev_we   <= mem_we_o;
        if (!rst_n) begin
            mem_ack_i   <= 1'b0;
            mem_rdata_i <= '0;
            wcnt        <= 0;
            acc_total   <= 0;
            stall_bad   <= 0;
            for (int t = 0; t < 256; t++) begin
                mem[t*2]   <= {t[7:0], ~t[7:0]};
                mem[t*2+1] <= {~t[7:0], t[7:0]};
            end
        end else if (mem_ack_i) begin
            mem_ack_i <= 1'b0;
            wcnt      <= 0;
        end else if (mem_req_o) begin
            if (wcnt != 0 && (mem_addr_o != prev_addr || mem_we_o != prev_we))
                stall_bad <= stall_bad + 1;
            if (wcnt >= lat) begin
                mem_ack_i <= 1'b1;
                acc_total <= acc_total + 1;
                if (mem_we_o) begin
                    mem[mem_addr_o[12:1]] <= mem_wdata_o;
                    wr_hist[0] <= mem_addr_o;
                    wr_hist[1] <= wr_hist[0];
                    wr_hist[2] <= wr_hist[1];
                end else begin
                    mem_rdata_i <= mem[mem_addr_o[12:1]];
                end
            end
            wcnt <= wcnt + 1;
        end
    end

    function automatic logic [15:0] ip_vec(input logic [7:0] t);
        return {t, ~t};
    endfunction

    function automatic logic [15:0] cs_vec(input logic [7:0] t);
        return {~t, t};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] val);
        @(posedge clk); #1;
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic set_regs(input logic [15:0] sp, fl, cs, ip);
        write_reg(2'd0, sp);
        write_reg(2'd1, fl);
        write_reg(2'd2, cs);
        write_reg(2'd3, ip);
    endtask

    task automatic issue(input logic st, input logic [7:0] typ, input logic sv,
                         input logic [7:0] op, input logic [7:0] imm, input logic rt);
        @(posedge clk); #1;
        start_i = st; start_type_i = typ; swi_valid_i = sv; swi_op_i = op;
        swi_imm_i = imm; ret_i = rt;
        @(posedge clk); #1;
        start_i = 1'b0; swi_valid_i = 1'b0; ret_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int k = 0; k < 300; k++) begin
            if (done_o) return;
            @(posedge clk); #1;
        end
        chk({tag, " done timeout"}, 32'd0, 32'd1);
    endtask

    // Return and compare restored state.
    task automatic do_return(input logic [15:0] sp, fl, cs, ip);
        issue(1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1);
        wait_done("R4");
        chk("R4 IP restored", ip_o, ip);
        chk("R4 CS restored", cs_o, cs);
        chk("R4 flags restored", flags_o, fl);
        chk("R4 SP restored", sp_o, sp);
    endtask

    // kind[39:36] op[35:28] imm[27:20] flags[19:4] lat[3:0]; kind 0 direct, 1 opcode
    localparam logic [39:0] VECS [0:7] = '{
        40'h0_00_20_0302_0,
        40'h0_00_FF_FFFF_2,
        40'h1_CD_41_0200_1,
        40'h1_CC_00_0100_0,
        40'h1_CE_00_0A00_2,
        40'h1_CE_00_0200_0,
        40'h1_90_00_0300_0,
        40'h0_00_00_0000_3
    };

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk("R11 reset SP", sp_o, 16'hFFFE);
        chk("R11 reset flags", flags_o, 16'h0002);
        chk("R11 reset CS", cs_o, 16'hFFFF);
        chk("R11 reset IP", ip_o, 16'h0000);
        chk("R9 reset busy low", busy_o, 1'b0);
        chk("R9 reset no request", mem_req_o, 1'b0);

        for (int i = 0; i < 8; i++) begin
            logic [3:0]  kind;
            logic [7:0]  op, imm, typ;
            logic [15:0] fl, cs0, ip0;
            int          cls, a0;
            string       tag;
            kind = VECS[i][39:36];
            op   = VECS[i][35:28];
            imm  = VECS[i][27:20];
            fl   = VECS[i][19:4];
            lat  = int'(VECS[i][3:0]);
            cs0  = 16'h1200 + 16'(i);
            ip0  = 16'h3400 + 16'(i);
            cls  = 0; typ = imm; tag = "R2";
            if (kind == 4'd1) begin
                if (op == 8'hCD)      begin tag = "R5"; end
                else if (op == 8'hCC) begin tag = "R6"; typ = 8'd3; end
                else if (op == 8'hCE) begin tag = "R7"; typ = 8'd4; cls = fl[11] ? 0 : 1; end
                else                  begin tag = "R8"; cls = 2; end
            end
            ss_i = 16'h0010;
            set_regs(16'h1000, fl, cs0, ip0);
            a0 = acc_total;
            issue(kind == 4'd0, imm, kind == 4'd1, op, imm, 1'b0);
            if (cls == 0) begin
                chk("R9 busy after accept", busy_o, 1'b1);
                wait_done(tag);
                chk({tag, " new IP from vector"}, ip_o, ip_vec(typ));
                chk("R2 new CS from vector", cs_o, cs_vec(typ));
                chk("R3 IF/TF cleared", flags_o, fl & 16'hFCFF);
                chk("R1 SP lowered by 6", sp_o, 16'h0FFA);
                chk("R1 flags pushed first", mem[20'h010FE >> 1], fl);
                chk("R1 CS pushed second", mem[20'h010FC >> 1], cs0);
                chk("R1 IP pushed third", mem[20'h010FA >> 1], ip0);
                chk("R1 five accesses", acc_total - a0, 5);
                do_return(16'h1000, fl, cs0, ip0);
            end else if (cls == 1) begin
                wait_done(tag);
                chk("R7 no memory traffic", acc_total - a0, 0);
                chk("R7 IP unchanged", ip_o, ip0);
                chk("R7 SP unchanged", sp_o, 16'h1000);
                chk("R7 flags unchanged", flags_o, fl);
            end else begin
                for (int k = 0; k < 4; k++) begin
                    chk("R8 busy stays low", busy_o, 1'b0);
                    @(posedge clk); #1;
                end
                chk("R8 no memory traffic", acc_total - a0, 0);
                chk("R8 IP unchanged", ip_o, ip0);
                chk("R8 CS unchanged", cs_o, cs0);
                chk("R8 SP unchanged", sp_o, 16'h1000);
            end
        end

        // R13: stack frame crosses the 20-bit wrap.
        lat = 1;
        ss_i = 16'hFFFF;
        set_regs(16'h0200, 16'h0300, 16'h5555, 16'h6666);
        issue(1'b1, 8'h10, 1'b0, 8'h00, 8'h00, 1'b0);
        wait_done("R13");
        chk("R13 first push wraps", wr_hist[2], 20'h001EE);
        chk("R13 second push wraps", wr_hist[1], 20'h001EC);
        chk("R13 third push wraps", wr_hist[0], 20'h001EA);
        chk("R13 SP after entry", sp_o, 16'h01FA);
        do_return(16'h0200, 16'h0300, 16'h5555, 16'h6666);

        // R12: direct request beats opcode and return.
        ss_i = 16'h0010;
        set_regs(16'h1000, 16'h0200, 16'h1111, 16'h2222);
        issue(1'b1, 8'h22, 1'b1, 8'hCC, 8'h00, 1'b1);
        wait_done("R12");
        chk("R12 direct type wins", ip_o, ip_vec(8'h22));
        do_return(16'h1000, 16'h0200, 16'h1111, 16'h2222);
        // R12: recognised opcode beats return.
        issue(1'b0, 8'h00, 1'b1, 8'hCD, 8'h33, 1'b1);
        wait_done("R12");
        chk("R12 opcode beats return", ip_o, ip_vec(8'h33));
        chk("R12 SP after opcode entry", sp_o, 16'h0FFA);
        do_return(16'h1000, 16'h0200, 16'h1111, 16'h2222);

        // R9 / R11: commands and register writes while busy are ignored.
        lat = 2;
        issue(1'b1, 8'h05, 1'b0, 8'h00, 8'h00, 1'b0);
        @(posedge clk); #1;
        ret_i = 1'b1; start_i = 1'b1; start_type_i = 8'h06;
        wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 16'hAAAA;
        @(posedge clk); #1;
        ret_i = 1'b0; start_i = 1'b0; wr_en_i = 1'b0;
        wait_done("R9");
        chk("R9 second command ignored", ip_o, ip_vec(8'h05));
        chk("R11 write while busy ignored", sp_o, 16'h0FFA);
        @(posedge clk); #1;
        chk("R9 done is a single pulse", done_o, 1'b0);
        chk("R9 busy drops after done", busy_o, 1'b0);
        do_return(16'h1000, 16'h0200, 16'h1111, 16'h2222);

        chk("R10 request held while stalled", stall_bad, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule